// File: doc/BRIEF.md
# FSK Proximity Tag Waveform Generator

This block produces the coil-control bit stream of a low-frequency proximity tag that uses frequency-shift keying. It carries a 44-bit identifier, supplied as a high word and a 32-bit low word. The block advances one output sample on every rising edge of its clock, which is the carrier-derived clock. When `coil_open` is high the load coil is open. When it is low the coil is shorted.

No sample buffer is stored. The frame is built on the fly by two counter stages:

- A burst stage counts samples within a sub-carrier cycle, and cycles within a half-bit.
- A frame stage walks the frame in order: a lead marker, the preamble, a nibble marker before every four identifier bits, and the Manchester pairs of the data bits.

A start strobe launches transmission, and the frame then repeats back to back. The stop input ends transmission on the next edge.

Top module: `fsk_tag_wavegen`

## Requirements
- R1: A short cycle is the 8-sample pattern 1,1,0,0,0,0,0,0. A short half-bit is six short cycles, 48 samples.
- R2: A long cycle is the 10-sample pattern 1,1,1,0,0,0,0,0,0,0. A long half-bit is five long cycles, 50 samples.
- R3: A data bit of value 1 is sent as a long half-bit followed by a short half-bit. A data bit of value 0 is sent as a short half-bit followed by a long half-bit.
- R4: Each frame opens with one lone short cycle (8 samples). Eight half-bits follow, of kinds short, short, short, long, long, long, short, long.
- R5: The identifier bits go out from bit 43 down to bit 0. Bits 43..32 are `id_hi[11:0]` and bits 31..0 are `id_lo`.
- R6: One lone short cycle (8 samples) precedes each group of four identifier bits, that is, before bits 43, 39, 35, ... 3.
- R7: A frame lasts 4800 samples. The next frame starts with no gap on the following sample, and this continues until stopped.
- R8: A start accepted while idle raises `busy` on that edge. After that edge `coil_open` shows sample 0 of the frame, and each later edge advances one sample.
- R9: A start with `id_hi` greater than 0xFFF is rejected: `busy` and `coil_open` stay low. A start with `id_hi` equal to 0xFFF is accepted.
- R10: With `stop` high, the next edge leaves `busy` low and `coil_open` low, even if `start` is also high.
- R11: A start while busy is ignored. The frame continues with the identifier that was latched first.
- R12: After reset, `busy` and `coil_open` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-derived sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled on the clock edge |
| stop | input | 1 | Stop request, takes effect on the next edge |
| id_hi | input | 16 | High identifier word, only 12 bits valid |
| id_lo | input | 32 | Low identifier word |
| coil_open | output | 1 | 1 = coil open, 0 = coil shorted |
| busy | output | 1 | High while transmitting |

## Verification
The hardest condition to reach from the ports is the frame boundary: the last half-bit of bit 0 rolls over into the lead marker of the next frame.

The bench reaches it by letting whole frames of 4800 samples run past the wrap point before it stops. It does this for the all-ones identifier, the all-zeros identifier and random identifiers. Each sample is compared against a position-walking model.

Start requests sent while busy use a complemented identifier, so any wrongly accepted restart shows up in the following data bits.

// File: rtl/fsk_tag_pkg.sv
package fsk_tag_pkg;
    typedef enum logic [1:0] {
        SEG_LEAD = 2'd0,
        SEG_PRE  = 2'd1,
        SEG_NIB  = 2'd2,
        SEG_DATA = 2'd3
    } seg_e;
endpackage

// File: rtl/fsk_burst_gen.sv
module fsk_burst_gen #(
    parameter int SHORT_LEN  = 8,
    parameter int LONG_LEN   = 10,
    parameter int SHORT_HIGH = 2,
    parameter int LONG_HIGH  = 3,
    parameter int SHORT_REPS = 6,
    parameter int LONG_REPS  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic is_lone,
    input  logic is_long,
    output logic level,
    output logic seg_last
);
    localparam int MAX_LEN  = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
    localparam int MAX_REPS = (LONG_REPS > SHORT_REPS) ? LONG_REPS : SHORT_REPS;
    localparam int SW = $clog2(MAX_LEN);
    localparam int CW = $clog2(MAX_REPS);

    typedef struct packed {
        logic [SW-1:0] samp;
        logic [CW-1:0] cyc;
    } burst_s;

    burst_s st_q, st_d;
    logic [SW-1:0] len_m1, hi_lim;
    logic [CW-1:0] reps_m1;
    logic samp_end, cyc_end;

    always_comb begin
        len_m1   = is_long ? SW'(LONG_LEN - 1) : SW'(SHORT_LEN - 1);
        hi_lim   = is_long ? SW'(LONG_HIGH) : SW'(SHORT_HIGH);
        reps_m1  = is_lone ? '0 : (is_long ? CW'(LONG_REPS - 1) : CW'(SHORT_REPS - 1));
        samp_end = (st_q.samp == len_m1);
        cyc_end  = (st_q.cyc == reps_m1);
        st_d     = st_q;
        if (clr) begin
            st_d = '0;
        end else if (adv) begin
            if (samp_end) begin
                st_d.samp = '0;
                st_d.cyc  = cyc_end ? '0 : st_q.cyc + 1'b1;
            end else begin
                st_d.samp = st_q.samp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level    = (st_q.samp < hi_lim);
    assign seg_last = samp_end & cyc_end;

    // the kind chosen by the sequencer must never leave the counters past their limit
    assert_samp_in_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (st_q.samp <= len_m1));
    assert_cyc_in_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (st_q.cyc <= reps_m1));
endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
    import fsk_tag_pkg::*;
#(
    parameter int ID_W = 44,
    parameter int NIB_BITS = 4,
    parameter int PRE_HALVES = 8,
    parameter logic [PRE_HALVES-1:0] PRE_LONG = 8'b1011_1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    input  logic            seg_last,
    input  logic [ID_W-1:0] id,
    output logic            is_lone,
    output logic            is_long
);
    localparam int BW = $clog2(ID_W);
    localparam int PW = $clog2(PRE_HALVES);

    typedef struct packed {
        seg_e          seg;
        logic [PW-1:0] pre;
        logic [BW-1:0] bidx;
        logic          half;
    } seq_s;

    seq_s st_q, st_d;
    logic [BW-1:0] bnext;

    always_comb begin
        bnext = st_q.bidx - 1'b1;
        st_d  = st_q;
        if (clr) begin
            st_d.seg  = SEG_LEAD;
            st_d.pre  = '0;
            st_d.bidx = BW'(ID_W - 1);
            st_d.half = 1'b0;
        end else if (adv && seg_last) begin
            case (st_q.seg)
                SEG_LEAD: begin
                    st_d.seg = SEG_PRE;
                    st_d.pre = '0;
                end
                SEG_PRE: begin
                    if (st_q.pre == PW'(PRE_HALVES - 1)) begin
                        st_d.seg  = SEG_NIB;
                        st_d.bidx = BW'(ID_W - 1);
                    end else begin
                        st_d.pre = st_q.pre + 1'b1;
                    end
                end
                SEG_NIB: begin
                    st_d.seg  = SEG_DATA;
                    st_d.half = 1'b0;
                end
                default: begin
                    if (!st_q.half) begin
                        st_d.half = 1'b1;
                    end else if (st_q.bidx == '0) begin
                        st_d.seg  = SEG_LEAD;
                        st_d.half = 1'b0;
                    end else begin
                        st_d.bidx = bnext;
                        st_d.half = 1'b0;
                        if ((int'(bnext) % NIB_BITS) == NIB_BITS - 1) st_d.seg = SEG_NIB;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.seg  <= SEG_LEAD;
            st_q.pre  <= '0;
            st_q.bidx <= BW'(ID_W - 1);
            st_q.half <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        is_lone = (st_q.seg == SEG_LEAD) || (st_q.seg == SEG_NIB);
        case (st_q.seg)
            SEG_PRE:  is_long = PRE_LONG[st_q.pre];
            SEG_DATA: is_long = id[st_q.bidx] ^ st_q.half;
            default:  is_long = 1'b0;
        endcase
    end

    assert_bit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bidx <= BW'(ID_W - 1));
    assert_nibble_marker_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seg == SEG_NIB) |-> ((int'(st_q.bidx) % NIB_BITS) == NIB_BITS - 1));
    assert_frame_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv && seg_last && st_q.seg == SEG_DATA && st_q.half && st_q.bidx == '0)
        |=> (st_q.seg == SEG_LEAD));
endmodule

// File: rtl/fsk_tag_wavegen.sv
module fsk_tag_wavegen #(
    parameter int ID_W = 44,
    parameter int LO_W = 32,
    parameter int HI_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            stop,
    input  logic [HI_W-1:0] id_hi,
    input  logic [LO_W-1:0] id_lo,
    output logic            coil_open,
    output logic            busy
);
    localparam int HI_BITS = ID_W - LO_W;
    localparam logic [HI_W-1:0] HI_MAX = HI_W'((1 << HI_BITS) - 1);

    typedef struct packed {
        logic            busy;
        logic [ID_W-1:0] id;
    } ctl_s;

    ctl_s ctl_q, ctl_d;
    logic hi_ok, start_ok, adv, is_lone, is_long, level, seg_last;

    always_comb begin
        hi_ok    = (id_hi <= HI_MAX);
        start_ok = start & ~stop & ~ctl_q.busy & hi_ok;
        adv      = ctl_q.busy & ~stop;
        ctl_d    = ctl_q;
        if (start_ok) ctl_d.id = {id_hi[HI_BITS-1:0], id_lo};
        if (stop)          ctl_d.busy = 1'b0;
        else if (start_ok) ctl_d.busy = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    fsk_frame_seq #(.ID_W(ID_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .adv(adv), .seg_last(seg_last),
        .id(ctl_q.id), .is_lone(is_lone), .is_long(is_long)
    );

    fsk_burst_gen i_burst (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .adv(adv),
        .is_lone(is_lone), .is_long(is_long), .level(level), .seg_last(seg_last)
    );

    assign busy      = ctl_q.busy;
    assign coil_open = ctl_q.busy & level;

    assert_first_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop && !busy && id_hi <= HI_MAX) |=> (busy && coil_open));
    assert_reject_wide_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && id_hi > HI_MAX) |=> !busy);
    assert_stop_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!busy && !coil_open));
    assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !stop) |=> busy);
endmodule

// File: tb/test_fsk_tag_wavegen.sv
module test_fsk_tag_wavegen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic [15:0] id_hi = '0;
    logic [31:0] id_lo = '0;
    logic        coil_open, busy;
    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    localparam int FRAME = 4800;

    always #4 clk = ~clk;

    fsk_tag_wavegen i_fsk_tag_wavegen (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .id_hi(id_hi), .id_lo(id_lo), .coil_open(coil_open), .busy(busy)
    );

    function automatic logic half_lvl(int kind, int p);
        if (kind == 8) return (p % 8) < 2;
        return (p % 10) < 3;
    endfunction

    function automatic int half_len(int kind);
        return (kind == 8) ? 48 : 50;
    endfunction

    function automatic logic ref_bit(logic [43:0] id, int k);
        int p = k % FRAME;
        int pre[8] = '{8, 8, 8, 10, 10, 10, 8, 10};
        if (p < 8) return p < 2;
        p -= 8;
        for (int h = 0; h < 8; h++) begin
            if (p < half_len(pre[h])) return half_lvl(pre[h], p);
            p -= half_len(pre[h]);
        end
        for (int b = 43; b >= 0; b--) begin
            int t0 = id[b] ? 10 : 8;
            int t1 = id[b] ? 8 : 10;
            if (b % 4 == 3) begin
                if (p < 8) return p < 2;
                p -= 8;
            end
            if (p < half_len(t0)) return half_lvl(t0, p);
            p -= half_len(t0);
            if (p < half_len(t1)) return half_lvl(t1, p);
            p -= half_len(t1);
        end
        return 1'b0;
    endfunction

    function automatic string region(int k);
        int p = k % FRAME;
        if (k >= FRAME && p < 8) return "R7";
        if (p < 8) return "R4";
        if (p < 152) return "R1 R4";
        if (p < 302) return "R2 R4";
        if (p < 400) return "R4";
        return "R3 R5 R6";
    endfunction

    task automatic check(logic act, logic exp, string req);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check(busy, 1'b0, "R10 busy");
        check(coil_open, 1'b0, "R10 coil");
        repeat (3) @(negedge clk);
        check(busy | coil_open, 1'b0, "R10 idle");
    endtask

    task automatic run_frame(logic [15:0] hi, logic [31:0] lo, int n, int inject_at);
        logic [43:0] id = {hi[11:0], lo};
        start = 1'b1; id_hi = hi; id_lo = lo;
        @(negedge clk);
        start = 1'b0;
        check(busy, 1'b1, (hi == 16'h0FFF) ? "R9 max accepted" : "R8 busy");
        for (int k = 0; k < n; k++) begin
            check(coil_open, ref_bit(id, k), region(k));
            if (k == inject_at) begin
                start = 1'b1; id_hi = ~hi & 16'h0FFF; id_lo = ~lo;
            end
            @(negedge clk);
            if (k == inject_at) begin
                start = 1'b0;
                check(busy, 1'b1, "R11 busy");
            end
        end
        do_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check(busy, 1'b0, "R12 busy");
        check(coil_open, 1'b0, "R12 coil");
        rst_n = 1'b1;
        @(negedge clk);

        // rejected starts with wide high word
        for (int r = 0; r < 3; r++) begin
            start = 1'b1;
            id_hi = 16'h1000 | 16'($urandom_range(0, 16'hEFFF));
            id_lo = $urandom;
            @(negedge clk);
            start = 1'b0;
            for (int c = 0; c < 10; c++) begin
                check(busy | coil_open, 1'b0, "R9 rejected");
                @(negedge clk);
            end
        end

        // directed corner identifiers across the frame wrap
        run_frame(16'h0FFF, 32'hFFFF_FFFF, FRAME + 200, -1);
        run_frame(16'h0000, 32'h0000_0000, FRAME + 200, -1);
        run_frame(16'h0A5C, 32'h3C96_0F1E, 2 * FRAME + 20, -1);

        // random identifiers and lengths, with an ignored restart
        for (int r = 0; r < 4; r++) begin
            logic [15:0] h = 16'($urandom_range(0, 16'h0FFF));
            logic [31:0] l = $urandom;
            int n = $urandom_range(600, FRAME + 400);
            run_frame(h, l, n, (r % 2 == 0) ? n / 3 : -1);
        end

        // stop together with start while busy, and while idle
        start = 1'b1; id_hi = 16'h0123; id_lo = 32'h89AB_CDEF;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        start = 1'b1; stop = 1'b1;
        @(negedge clk);
        check(busy, 1'b0, "R10 stop beats start busy");
        @(negedge clk);
        check(busy | coil_open, 1'b0, "R10 stop beats start idle");
        start = 1'b0; stop = 1'b0;
        @(negedge clk);
        check(busy, 1'b0, "R10 stays idle");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule